// File: doc/BRIEF.md
# Binary-Weighted Programmable Delay Line

This block delays a data word by a whole number of clock cycles that is chosen at run time. The delay comes from a chain of fixed shift-register sections whose lengths are successive powers of two. Each section has its own bypass multiplexer, so any combination of sections can be placed in the data path. With the default six sections (1, 2, 4, 8, 16 and 32 stages) the delay spans 0 to 63 cycles and always equals the unsigned value of the select word.

Every section shifts on every clock, whether it is in the path or bypassed. The data held in a bypassed section therefore stays a true record of what reached its input. When the select word changes, the output is guaranteed only after the new delay has elapsed. Samples before that point may mix data from the old path and the new one. A select of zero joins input to output through the multiplexers alone, so the output follows the input in the same cycle.

Top module: `prog_delay_line`

## Requirements
- R1: With the select word held constant, `dout` in clock cycle k equals `din` from cycle k−D, where D is the unsigned value of `dly_sel`.
- R2: When `dly_sel` is zero, `dout` equals `din` combinationally in the same cycle, with no register in the path.
- R3: Bit i of `dly_sel` places a section of exactly 2^i stages in the path, so a select with only bit i set gives a delay of 2^i cycles.
- R4: When several select bits are set, the delays of the selected sections add together.
- R5: A clock edge with `rst_n` low clears every stage to zero. After reset is released, a nonzero delay D produces zero for the first D cycles and then the input from the cycles after release.
- R6: Bypassed sections keep shifting. If the path into a section is unchanged, setting that section's select bit gives correct output from the first cycle after the change.
- R7: After any change of `dly_sel` to a value D, every output sample from D cycles after the change onward follows R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all stages capture on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset that clears all stages |
| din | input | DATA_W | Data word entering the line |
| dly_sel | input | NUM_SEG | Delay in cycles, unsigned; bit i switches in the 2^i-stage section |
| dout | output | DATA_W | Delayed data word |

## Verification
The bench sweeps every select value from 0 to 63 and compares the output with a history of the inputs, indexed by the select value. A section of the wrong length, or a select bit wired to the wrong section, shows up as output that is early or late by the difference. A registered bypass path would add a cycle at select zero. The bench checks that the output reads all zeros after reset, which a design that never clears its stages would fail. It also switches on a high section after a long run, which exposes a design that stops shifting a section while it is bypassed, because that section would hand out stale words. Changes of the select word in the middle of a stream check that the output becomes correct once the new delay has run out.

// File: rtl/dly_pkg.sv
// Package: shared constants and helpers for the programmable delay line.
// Assumes section i holds 2**i stages; callers keep NUM_SEG small enough
// that the longest section stays a few thousand registers at most.
package dly_pkg;

    // Number of register stages in section idx.
    function automatic int unsigned seg_len(input int unsigned idx);
        return 32'd1 << idx;
    endfunction

    // Largest delay reachable with nseg sections (all bits set).
    function automatic int unsigned max_delay(input int unsigned nseg);
        return (32'd1 << nseg) - 32'd1;
    endfunction

endpackage

// File: rtl/dly_segment.sv
// Module: fixed-length shift register section of the delay line.
// Shifts one position on every clock, whatever the select word says, so
// its contents always record the words that reached seg_in.
// Assumes a synchronous active-low reset that clears every stage.
module dly_segment #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned LEN    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] seg_in,
    output logic [DATA_W-1:0] seg_out
);

    localparam int unsigned LAST = LEN - 1;

    logic [DATA_W-1:0] stage_q [LEN];

    // Shift chain: clear on reset, otherwise move every word one stage on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int unsigned s = 0; s < LEN; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            stage_q[0] <= seg_in;
            for (int unsigned s = 1; s < LEN; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    // Output is the oldest word in the section.
    always_comb begin
        seg_out = stage_q[LAST];
    end

endmodule

// File: rtl/dly_bypass_mux.sv
// Module: 2:1 selector that routes data through a section or around it.
// Purely combinational; assumes both inputs are valid in the same cycle.
module dly_bypass_mux #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              use_seg,
    input  logic [DATA_W-1:0] from_seg,
    input  logic [DATA_W-1:0] around_seg,
    output logic [DATA_W-1:0] mux_out
);

    // Pick the section output when selected, the bypass path otherwise.
    always_comb begin
        mux_out = use_seg ? from_seg : around_seg;
    end

endmodule

// File: rtl/prog_delay_line.sv
// Module: programmable delay line built from binary-weighted sections.
// Section i (2**i stages) is placed in the path when dly_sel[i] is set, so
// the delay equals the unsigned value of dly_sel. Assumes dly_sel is held
// steady for at least its own value in cycles before output is relied on.
module prog_delay_line #(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned NUM_SEG = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DATA_W-1:0]  din,
    input  logic [NUM_SEG-1:0] dly_sel,
    output logic [DATA_W-1:0]  dout
);

    import dly_pkg::*;

    localparam int unsigned NUM_TAPS = NUM_SEG + 1;

    // tap[i] feeds section i; tap[i+1] is the output of its bypass mux.
    logic [DATA_W-1:0] tap     [NUM_TAPS];
    logic [DATA_W-1:0] seg_q   [NUM_SEG];

    // Chain entry point.
    always_comb begin
        tap[0] = din;
    end

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_stage
        dly_segment #(
            .DATA_W (DATA_W),
            .LEN    (seg_len(g))
        ) u_seg (
            .clk     (clk),
            .rst_n   (rst_n),
            .seg_in  (tap[g]),
            .seg_out (seg_q[g])
        );

        dly_bypass_mux #(
            .DATA_W (DATA_W)
        ) u_mux (
            .use_seg    (dly_sel[g]),
            .from_seg   (seg_q[g]),
            .around_seg (tap[g]),
            .mux_out    (tap[g+1])
        );
    end

    // Chain exit point.
    always_comb begin
        dout = tap[NUM_SEG];
    end

endmodule

// File: rtl/prog_delay_line_chk.sv
// Module: assertion checker for prog_delay_line, attached through bind.
// Observes only the ports; windows are short fixed depths.
module prog_delay_line_chk #(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned NUM_SEG = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic [DATA_W-1:0]  din,
    input logic [NUM_SEG-1:0] dly_sel,
    input logic [DATA_W-1:0]  dout
);

    localparam logic [NUM_SEG-1:0] SEL_ONE   = NUM_SEG'(1);
    localparam logic [NUM_SEG-1:0] SEL_TWO   = NUM_SEG'(2);
    localparam logic [NUM_SEG-1:0] SEL_THREE = NUM_SEG'(3);

    // R2: select zero gives a straight path.
    a_r2_zero_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_sel == '0) |-> (dout == din));

    // R1: one-cycle delay follows the previous input.
    a_r1_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_sel == SEL_ONE && $past(rst_n)) |-> (dout == $past(din)));

    // R3: the 2-stage section alone delays by two cycles.
    a_r3_two_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_sel == SEL_TWO && $past(dly_sel) == SEL_TWO && $past(dly_sel, 2) == SEL_TWO
         && $past(rst_n) && $past(rst_n, 2)) |-> (dout == $past(din, 2)));

    // R4: two sections together delay by the sum of their lengths.
    a_r4_sum_three: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_sel == SEL_THREE && $past(dly_sel) == SEL_THREE && $past(dly_sel, 2) == SEL_THREE
         && $past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3)) |-> (dout == $past(din, 3)));

    // R5: first cycle after a reset edge reads cleared stages.
    a_r5_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) && dly_sel != '0) |-> (dout == '0));

endmodule

bind prog_delay_line prog_delay_line_chk #(
    .DATA_W  (DATA_W),
    .NUM_SEG (NUM_SEG)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (din),
    .dly_sel (dly_sel),
    .dout    (dout)
);

// File: tb/prog_delay_line_tb.sv
module prog_delay_line_tb;

    localparam int W  = 8;
    localparam int NS = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [W-1:0]  din;
    logic [NS-1:0] sel;
    logic [W-1:0]  dout;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int valid_from = 0;
    int sel_since = 0;
    bit finished = 1'b0;
    logic [W-1:0] hist [0:127];

    always #10 clk = ~clk;

    prog_delay_line #(.DATA_W(W), .NUM_SEG(NS)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (din),
        .dly_sel (sel),
        .dout    (dout)
    );

    function automatic logic [W-1:0] pat(input int k);
        return W'((k * 29 + 7) ^ (k >> 3));
    endfunction

    function automatic string tag_for(input int d);
        if (d == 0) return "R2";
        if ((d & (d - 1)) == 0) return "R3";
        return "R4";
    endfunction

    // mode: 0 no check, 1 check when the delay rule allows, 2 check regardless
    task automatic tick(input logic [W-1:0] d, input logic [NS-1:0] s,
                        input logic r, input string tag, input int mode);
        int dl;
        logic [W-1:0] expv;
        @(posedge clk);
        #1;
        cyc++;
        if (!rst_n) valid_from = cyc;
        if (s != sel) sel_since = cyc;
        din = d;
        sel = s;
        rst_n = r;
        hist[cyc % 128] = d;
        #9;
        dl = int'(s);
        if (r && mode != 0 &&
            (mode == 2 || cyc - dl >= sel_since || sel_since <= valid_from)) begin
            expv = (cyc - dl >= valid_from) ? hist[(cyc - dl) % 128] : '0;
            checks++;
            if (dout !== expv) begin
                errors++;
                $display("FAIL %s cycle %0d sel %0d: dout=%h expected=%h",
                         tag, cyc, dl, dout, expv);
            end
        end
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        summary();
    end

    initial begin
        rst_n = 1'b0;
        din   = '0;
        sel   = 6'd63;
        // Reset with nonzero data present (R5)
        for (int i = 0; i < 4; i++) tick(8'hA5, 6'd63, 1'b0, "R5", 0);
        tick(8'h3C, 6'd63, 1'b1, "R5", 1);
        checks++;
        if (dout !== '0) begin
            errors++;
            $display("FAIL R5 reset state: dout=%h expected=00", dout);
        end
        // Zeros then data through the longest delay (R5, R1)
        for (int i = 0; i < 80; i++) tick(pat(cyc), 6'd63, 1'b1, "R5", 1);

        // Sweep every delay value (R1..R4, R7)
        for (int dv = 0; dv < 64; dv++) begin
            for (int i = 0; i < dv + 8; i++)
                tick(pat(cyc), NS'(dv), 1'b1, tag_for(dv), 1);
        end

        // Enable a higher section after a long run: correct at once (R6)
        for (int i = 0; i < 50; i++) tick(pat(cyc), 6'd1, 1'b1, "R1", 1);
        for (int i = 0; i < 5; i++)  tick(pat(cyc), 6'd33, 1'b1, "R6", 2);
        for (int i = 0; i < 50; i++) tick(pat(cyc), 6'd2, 1'b1, "R1", 1);
        for (int i = 0; i < 5; i++)  tick(pat(cyc), 6'd34, 1'b1, "R6", 2);
        for (int i = 0; i < 10; i++) tick(pat(cyc), 6'd1, 1'b1, "R1", 1);
        for (int i = 0; i < 5; i++)  tick(pat(cyc), 6'd3, 1'b1, "R6", 2);

        // Shorten, then lengthen, in mid stream (R7)
        for (int i = 0; i < 60; i++) tick(pat(cyc), 6'd40, 1'b1, "R7", 1);
        for (int i = 0; i < 20; i++) tick(pat(cyc), 6'd5, 1'b1, "R7", 1);
        for (int i = 0; i < 70; i++) tick(pat(cyc), 6'd42, 1'b1, "R7", 1);

        // Reset in mid stream clears the history (R5)
        for (int i = 0; i < 30; i++) tick(pat(cyc), 6'd20, 1'b1, "R1", 1);
        tick(8'hFF, 6'd20, 1'b0, "R5", 0);
        for (int i = 0; i < 40; i++) tick(pat(cyc), 6'd20, 1'b1, "R5", 1);

        summary();
    end

endmodule